// File: doc/BRIEF.md
# Comparator Event Interrupt Controller

This block is the digital side of an on-chip analog comparator. It brings the comparator's output bit into the clock domain through a short synchronizer, watches it for a chosen kind of transition, and records hits in a sticky interrupt flag. The flag produces an interrupt request when both the local enable and the global interrupt enable are set. It clears when the CPU acknowledges the interrupt or when software writes a one to it.

The block can also pass the synchronized comparator level to a timer's input-capture trigger. It produces a select that picks the comparator's negative input: either the ADC multiplexer channel or the dedicated pin, depending on a control bit and on whether the ADC is running. Software reaches the controls through a two-word register port. Writes take effect on the clock edge and reads are combinational.

Top module: `cmp_irq_ctrl`

## Requirements
- R1: With the mode field at 2'b00, any change of the synchronized comparator level sets the flag.
- R2: Mode 2'b10 sets the flag only on a 1-to-0 change of the level, and mode 2'b11 only on a 0-to-1 change.
- R3: Mode 2'b01 is reserved and never sets the flag, whatever the comparator does.
- R4: A one-cycle pulse on `irq_ack` clears the flag on the next clock edge.
- R5: Writing the status word (address 1) with bit 0 at 1 clears the flag. Writing it with bit 0 at 0 leaves the flag unchanged.
- R6: `irq_req` is high exactly when the flag, the enable bit and `gie` are all 1.
- R7: With the capture-route bit at 1, `cap_trig` follows the synchronized comparator level. With the bit at 0, `cap_trig` stays 0.
- R8: `neg_sel_mux` is 1 only when the mux-enable bit is 1 and `adc_en` is 0. Otherwise it is 0, which selects the dedicated pin.
- R9: If a new event and a clear (acknowledge or write-one) fall in the same cycle, the flag ends up set.
- R10: After reset, all control bits and the flag are 0. A comparator input that is already high at reset does not set the flag.
- R11: A change on `cmp_in` that is set up before a clock edge reaches the flag on the third rising edge from that point: two synchronizer stages, then the flag register.
- R12: The control word is at address 0: bit 0 enable, bits 2:1 mode, bit 3 capture route, bit 4 mux enable, with its upper bits read as 0. The status word is at address 1: bit 0 flag, bit 1 synchronized level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_in | input | 1 | Asynchronous comparator output |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register address (0 control, 1 status) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| irq_ack | input | 1 | Interrupt acknowledge strobe |
| gie | input | 1 | Global interrupt enable |
| adc_en | input | 1 | ADC enabled |
| irq_req | output | 1 | Interrupt request |
| cap_trig | output | 1 | Timer input-capture trigger |
| neg_sel_mux | output | 1 | 1 selects the ADC multiplexer as the negative input, 0 selects the dedicated pin |

## Verification
The hardest case to reach from the ports is a detected edge that lands in the same cycle as a clear. The edge is only visible internally, two clocks after the input moves. The stimulus changes `cmp_in`, counts two rising edges, then raises `irq_ack` for exactly the third edge, and checks that the flag is still set. Edge latency is pinned down by sampling the flag both one edge before and at the edge where it must rise. Every mode is also walked with both transition directions.

// File: rtl/cmp_irq_pkg.sv
package cmp_irq_pkg;

    localparam int DATA_W      = 8;
    localparam int SYNC_STAGES = 2;

    typedef enum logic [1:0] {
        MODE_TOGGLE = 2'b00,
        MODE_RSVD   = 2'b01,
        MODE_FALL   = 2'b10,
        MODE_RISE   = 2'b11
    } edge_mode_t;

    typedef struct packed {
        logic       mux_en;
        logic       cap_route;
        edge_mode_t mode;
        logic       irq_en;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    localparam logic ADDR_CTRL = 1'b0;
    localparam logic ADDR_STAT = 1'b1;

    function automatic logic edge_hit(edge_mode_t m, logic now, logic prev);
        logic hit;
        case (m)
            MODE_TOGGLE: hit = now ^ prev;
            MODE_FALL:   hit = prev & ~now;
            MODE_RISE:   hit = now & ~prev;
            default:     hit = 1'b0;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/cmp_sampler.sv
module cmp_sampler #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic smp_now,
    output logic smp_prev
);
    logic [STAGES-1:0] chain;
    logic              prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain  <= {STAGES{async_in}};
            prev_q <= async_in;
        end else begin
            chain  <= {chain[STAGES-2:0], async_in};
            prev_q <= chain[STAGES-1];
        end
    end

    assign smp_now  = chain[STAGES-1];
    assign smp_prev = prev_q;
endmodule

// File: rtl/cmp_ctrl_regs.sv
module cmp_ctrl_regs
    import cmp_irq_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr,
    input  logic          addr,
    input  logic [DW-1:0] wdata,
    input  logic          flag,
    input  logic          level,
    output ctrl_t         ctrl,
    output logic          clr_req,
    output logic [DW-1:0] rdata
);
    ctrl_t ctrl_q;
    logic  unused_hi;

    assign unused_hi = ^wdata[DW-1:CTRL_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (wr && addr == ADDR_CTRL) begin
            ctrl_q <= ctrl_t'(wdata[CTRL_W-1:0]);
        end
    end

    assign clr_req = wr && (addr == ADDR_STAT) && wdata[0];
    assign ctrl    = ctrl_q;

    always_comb begin
        rdata = '0;
        if (addr == ADDR_CTRL) begin
            rdata[CTRL_W-1:0] = ctrl_q;
        end else begin
            rdata[0] = flag;
            rdata[1] = level;
        end
    end
endmodule

// File: rtl/cmp_flag.sv
module cmp_flag (
    input  logic clk,
    input  logic rst,
    input  logic evt,
    input  logic ack,
    input  logic clr_req,
    output logic flag_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
        end else if (evt) begin
            flag_q <= 1'b1;
        end else if (ack || clr_req) begin
            flag_q <= 1'b0;
        end
    end
endmodule

// File: rtl/cmp_irq_ctrl.sv
module cmp_irq_ctrl
    import cmp_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cmp_in,
    input  logic              reg_wr,
    input  logic              reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              irq_ack,
    input  logic              gie,
    input  logic              adc_en,
    output logic              irq_req,
    output logic              cap_trig,
    output logic              neg_sel_mux
);
    ctrl_t      ctrl;
    edge_mode_t mode_w;
    logic       smp_now, smp_prev;
    logic       evt_w, clr_req, flag_q;

    cmp_sampler #(.STAGES(SYNC_STAGES)) u_sampler (
        .clk      (clk),
        .rst      (rst),
        .async_in (cmp_in),
        .smp_now  (smp_now),
        .smp_prev (smp_prev)
    );

    cmp_ctrl_regs #(.DW(DATA_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr      (reg_wr),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .flag    (flag_q),
        .level   (smp_now),
        .ctrl    (ctrl),
        .clr_req (clr_req),
        .rdata   (reg_rdata)
    );

    assign mode_w = ctrl.mode;
    assign evt_w  = edge_hit(mode_w, smp_now, smp_prev);

    cmp_flag u_flag (
        .clk     (clk),
        .rst     (rst),
        .evt     (evt_w),
        .ack     (irq_ack),
        .clr_req (clr_req),
        .flag_q  (flag_q)
    );

    assign irq_req     = flag_q & ctrl.irq_en & gie;
    assign cap_trig    = ctrl.cap_route & smp_now;
    assign neg_sel_mux = ctrl.mux_en & ~adc_en;
endmodule

// File: rtl/cmp_irq_ctrl_chk.sv
module cmp_irq_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       gie,
    input logic       adc_en,
    input logic       irq_ack,
    input logic       irq_req,
    input logic       cap_trig,
    input logic       neg_sel_mux,
    input logic [1:0] mode,
    input logic       cap_route,
    input logic       flag,
    input logic       evt,
    input logic       clr_req,
    input logic       smp_now,
    input logic       smp_prev
);
    p_toggle_sets_r1: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b00 && smp_now != smp_prev) |=> flag);

    p_fall_sets_r2: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b10 && smp_prev && !smp_now) |=> flag);

    p_reserved_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b01 && !flag) |=> !flag);

    p_ack_clears_r4: assert property (@(posedge clk) disable iff (rst)
        (irq_ack && !evt) |=> !flag);

    p_clear_loses_r9: assert property (@(posedge clk) disable iff (rst)
        (evt && (irq_ack || clr_req)) |=> flag);

    p_no_gie_no_req_r6: assert property (@(posedge clk) disable iff (rst)
        (!gie || !flag) |-> !irq_req);

    p_cap_off_r7: assert property (@(posedge clk) disable iff (rst)
        !cap_route |-> !cap_trig);

    p_adc_pin_sel_r8: assert property (@(posedge clk) disable iff (rst)
        adc_en |-> !neg_sel_mux);
endmodule

bind cmp_irq_ctrl cmp_irq_ctrl_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .gie         (gie),
    .adc_en      (adc_en),
    .irq_ack     (irq_ack),
    .irq_req     (irq_req),
    .cap_trig    (cap_trig),
    .neg_sel_mux (neg_sel_mux),
    .mode        (mode_w),
    .cap_route   (ctrl.cap_route),
    .flag        (flag_q),
    .evt         (evt_w),
    .clr_req     (clr_req),
    .smp_now     (smp_now),
    .smp_prev    (smp_prev)
);

// File: tb/cmp_irq_ctrl_tb.sv
module cmp_irq_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmp_in = 1'b0;
    logic       reg_wr = 1'b0;
    logic       reg_addr = 1'b1;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       irq_ack = 1'b0;
    logic       gie = 1'b0;
    logic       adc_en = 1'b0;
    logic       irq_req, cap_trig, neg_sel_mux;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    cmp_irq_ctrl dut_i (
        .clk(clk), .rst(rst), .cmp_in(cmp_in), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_ack(irq_ack), .gie(gie), .adc_en(adc_en), .irq_req(irq_req),
        .cap_trig(cap_trig), .neg_sel_mux(neg_sel_mux)
    );

    // {mode[1:0], from, to, expected flag}
    localparam logic [4:0] VEC [8] = '{
        {2'b00, 1'b0, 1'b1, 1'b1}, {2'b00, 1'b1, 1'b0, 1'b1},
        {2'b10, 1'b1, 1'b0, 1'b1}, {2'b10, 1'b0, 1'b1, 1'b0},
        {2'b11, 1'b0, 1'b1, 1'b1}, {2'b11, 1'b1, 1'b0, 1'b0},
        {2'b01, 1'b0, 1'b1, 1'b0}, {2'b01, 1'b1, 1'b0, 1'b0}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = 1'b1;
    endtask

    function automatic logic flag_rd();
        return reg_rdata[0];
    endfunction

    initial begin
        // R10: reset with the comparator already high
        cmp_in = 1'b1;
        cyc(3);
        rst = 1'b0;
        cyc(5);
        chk("R10 flag after reset", {7'd0, flag_rd()}, 8'd0);
        reg_addr = 1'b0; #1;
        chk("R10 ctrl after reset", reg_rdata, 8'h00);
        reg_addr = 1'b1; #1;
        chk("R10 outputs after reset", {5'd0, irq_req, cap_trig, neg_sel_mux}, 8'd0);

        // R1 R2 R3 R11: mode table walk
        foreach (VEC[i]) begin
            cmp_in = VEC[i][2];
            wr(1'b0, {5'd0, VEC[i][4:3], 1'b0});
            cyc(4);
            wr(1'b1, 8'h01);
            chk("R5 clear before vector", {7'd0, flag_rd()}, 8'd0);
            cmp_in = VEC[i][1];
            cyc(2);
            chk("R11 no early flag", {7'd0, flag_rd()}, 8'd0);
            cyc(1);
            chk($sformatf("R1/R2/R3 vec%0d (R1 R2 R3)", i), {7'd0, flag_rd()}, {7'd0, VEC[i][0]});
        end

        // R12: control readback and status level
        wr(1'b0, 8'hFF);
        reg_addr = 1'b0; #1;
        chk("R12 ctrl readback", reg_rdata, 8'h1F);
        reg_addr = 1'b1; #1;
        chk("R12 status level bit", {7'd0, reg_rdata[1]}, {7'd0, cmp_in});

        // R6: request gating (toggle mode, enabled)
        wr(1'b0, 8'h01);
        cmp_in = ~cmp_in;
        cyc(3);
        gie = 1'b0; #1;
        chk("R6 no gie", {7'd0, irq_req}, 8'd0);
        gie = 1'b1; #1;
        chk("R6 all set", {7'd0, irq_req}, 8'd1);
        wr(1'b0, 8'h00);
        chk("R6 enable off", {7'd0, irq_req}, 8'd0);

        // R5: write zero keeps, write one clears
        wr(1'b1, 8'h00);
        chk("R5 write zero keeps flag", {7'd0, flag_rd()}, 8'd1);
        wr(1'b1, 8'h01);
        chk("R5 write one clears flag", {7'd0, flag_rd()}, 8'd0);

        // R9 and R4: event coinciding with acknowledge, then ack alone
        cmp_in = ~cmp_in;
        cyc(3);
        chk("R9 preset flag", {7'd0, flag_rd()}, 8'd1);
        cmp_in = ~cmp_in;
        cyc(2);
        irq_ack = 1'b1;
        cyc(1);
        irq_ack = 1'b0;
        chk("R9 event beats ack", {7'd0, flag_rd()}, 8'd1);
        irq_ack = 1'b1;
        cyc(1);
        irq_ack = 1'b0;
        chk("R4 ack clears flag", {7'd0, flag_rd()}, 8'd0);

        // R9 with write-one clear
        cmp_in = ~cmp_in;
        cyc(2);
        wr(1'b1, 8'h01);
        chk("R9 event beats write-one", {7'd0, flag_rd()}, 8'd1);

        // R7: capture routing
        cmp_in = 1'b1;
        wr(1'b0, 8'h08);
        cyc(3);
        chk("R7 routed high", {7'd0, cap_trig}, 8'd1);
        wr(1'b0, 8'h00);
        chk("R7 route off", {7'd0, cap_trig}, 8'd0);

        // R8: negative-input select
        wr(1'b0, 8'h10);
        adc_en = 1'b0; #1;
        chk("R8 mux selected", {7'd0, neg_sel_mux}, 8'd1);
        adc_en = 1'b1; #1;
        chk("R8 adc on uses pin", {7'd0, neg_sel_mux}, 8'd0);
        adc_en = 1'b0;
        wr(1'b0, 8'h00);
        chk("R8 mux bit off", {7'd0, neg_sel_mux}, 8'd0);

        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule